// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block gives a debug host a path into system memory without involving a processor. The host sees three word-wide registers behind a small select field: a control word, a bus address and a bus data word. Writing the data word sends that value to memory at the held address. Setting a one-shot bit in the control word reads memory at the held address into the data word. An optional read-ahead mode makes every host read of the data word launch the next memory read. An optional auto-increment mode steps the address by one word after each successful access.

On the memory side the block is a bus master with five channels: read request, read response, write address, write data and write response. Only one transaction is ever in flight. Every request carries a transaction tag, and a response is taken only when it returns the tag of the outstanding request. A three-bit error field records a failed bus response or a host access that arrived while a transaction was still open. The host clears the field by writing ones to its bits. While the field is nonzero, no new bus access can be launched.

Top module: `dbg_sysbus_access`

## Requirements
- R1: After reset the control word reads 0x004, the address and data words read 0, and arValid, awValid and wValid are low. Host select codes: 0 = control, 1 = address, 2 = data. Control word fields: bit 0 = read trigger (always reads 0), bits 2:1 = access size (always reads 2, meaning 32 bits), bit 3 = auto-increment, bit 4 = read-ahead, bits 7:5 = error, bit 8 = busy.
- R2: A control write with bit 0 set, made while idle and with the error field zero after its own clear bits, drives arValid in the next cycle with the held address and a fresh tag. Busy reads 1 until the response arrives. After an OKAY response (status 0) the data word holds the returned data.
- R3: A data-word write made while idle with no error raises awValid and wValid together in the next cycle, carrying the held address and the written value. Each valid stays high, with its payload stable, until its own ready is seen. The two valids are never high while arValid is high. Busy stays 1 until the write response arrives.
- R4: With bit 3 set, the address grows by 4 after each access that completes OKAY. With bit 3 clear, the address is unchanged.
- R5: With bit 4 set, a host read of the data word returns its current value and, when idle with no error, launches a read at the held address in the next cycle. With bit 4 clear, a read of the data word launches nothing.
- R6: A read or write response whose tag differs from the outstanding request is ignored.
- R7: A response with nonzero status sets the error field to 2. It leaves the data word and the address unchanged and ends the access.
- R8: While busy, a host write of the address or data word, a host read of the data word, or a control write with bit 0 set has no effect on the address, the data or the bus. If the error field is 0 it becomes 7.
- R9: Writing the control word clears each error bit written as 1 and keeps each error bit written as 0.
- R10: While the error field is nonzero, data-word writes, read triggers and read-ahead reads launch no bus request, and the data word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostRe | input | 1 | Host register read strobe (matters for the data word only) |
| hostSel | input | 2 | Register select: 0 control, 1 address, 2 data |
| hostWdata | input | DATA_W | Host write value |
| hostRdata | output | DATA_W | Selected register value, combinational |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request ready |
| arAddr | output | DATA_W | Read request address |
| arId | output | ID_W | Read request tag |
| rValid | input | 1 | Read response valid |
| rId | input | ID_W | Read response tag |
| rData | input | DATA_W | Read response data |
| rStatus | input | 2 | Read response status, 0 = OKAY |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | output | DATA_W | Write address |
| awId | output | ID_W | Write tag |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | DATA_W | Write data |
| bValid | input | 1 | Write response valid |
| bId | input | ID_W | Write response tag |
| bStatus | input | 2 | Write response status, 0 = OKAY |

## Verification
Request valids are due in the cycle after the clock edge that takes the host write or the read-ahead read. The bench drives inputs on falling edges and samples on the falling edge right after that rising edge. Its memory model accepts a read request at once and answers on the following edge, so read data and the cleared busy bit are due two edges after the request appears. A write completes one edge after both beats have been taken. Rather than counting fixed delays for completions, the bench polls the busy bit, which has no side effect, and then compares the data word, the address, the error field and the memory model's log with values computed from the address arithmetic.

// File: rtl/dbg_sysbus_pkg.sv
package dbg_sysbus_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_FAULT = 3'd2;
  localparam logic [2:0] ERR_STALE = 3'd7;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam logic [1:0] SIZE_32   = 2'd2;

  localparam int CB_TRIG     = 0;
  localparam int CB_SIZE     = 1;
  localparam int CB_AUTOINC  = 3;
  localparam int CB_AUTOREAD = 4;
  localparam int CB_ERR      = 5;
  localparam int CB_BUSY     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } busState_e;

  typedef struct packed {
    logic wrAddr;
    logic wrCtrl;
    logic loadHost;
    logic loadBus;
    logic incAddr;
    logic setFault;
    logic setStale;
    logic bumpId;
  } strobe_t;

endpackage

// File: rtl/dbg_sysbus_ctrl.sv
module dbg_sysbus_ctrl
  import dbg_sysbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWe,
  input  logic       hostRe,
  input  logic [1:0] hostSel,
  input  logic       trigBit,
  input  logic [2:0] clrMask,
  input  logic [2:0] errQ,
  input  logic       autoInc,
  input  logic       autoRead,
  input  logic       arReady,
  input  logic       rValid,
  input  logic       rMatch,
  input  logic       rOkay,
  input  logic       awReady,
  input  logic       wReady,
  input  logic       bValid,
  input  logic       bMatch,
  input  logic       bOkay,
  output strobe_t    stb,
  output logic       arValid,
  output logic       awValid,
  output logic       wValid,
  output logic       busy
);

  busState_e stateQ, stateD;
  logic awDoneQ, awDoneD, wDoneQ, wDoneD;
  logic selCtrl, selAddr, selData;
  logic [2:0] errAfterClr;
  logic awNow, wNow;

  assign selCtrl = (hostSel == SEL_CTRL);
  assign selAddr = (hostSel == SEL_ADDR);
  assign selData = (hostSel == SEL_DATA);
  assign errAfterClr = (hostWe && selCtrl) ? (errQ & ~clrMask) : errQ;
  assign awNow = awDoneQ || awReady;
  assign wNow  = wDoneQ || wReady;

  always_comb begin
    stb = '0;
    stateD = stateQ;
    awDoneD = awDoneQ;
    wDoneD = wDoneQ;
    stb.wrCtrl = hostWe && selCtrl;
    if (stateQ == ST_IDLE) begin
      if (hostWe && selAddr) begin
        stb.wrAddr = 1'b1;
      end else if (hostWe && selData && errQ == ERR_NONE) begin
        stb.loadHost = 1'b1;
        stb.bumpId = 1'b1;
        stateD = ST_WR_REQ;
      end else if (hostWe && selCtrl && trigBit && errAfterClr == ERR_NONE) begin
        stb.bumpId = 1'b1;
        stateD = ST_RD_REQ;
      end else if (!hostWe && hostRe && selData && autoRead && errQ == ERR_NONE) begin
        stb.bumpId = 1'b1;
        stateD = ST_RD_REQ;
      end
    end else begin
      if ((hostWe && (selAddr || selData || (selCtrl && trigBit))) ||
          (!hostWe && hostRe && selData))
        stb.setStale = 1'b1;
      unique case (stateQ)
        ST_RD_REQ: if (arReady) stateD = ST_RD_WAIT;
        ST_RD_WAIT: if (rValid && rMatch) begin
          stb.loadBus = rOkay;
          stb.incAddr = rOkay && autoInc;
          stb.setFault = !rOkay;
          stateD = ST_IDLE;
        end
        ST_WR_REQ: begin
          if (awNow && wNow) begin
            awDoneD = 1'b0;
            wDoneD = 1'b0;
            stateD = ST_WR_WAIT;
          end else begin
            awDoneD = awNow;
            wDoneD = wNow;
          end
        end
        ST_WR_WAIT: if (bValid && bMatch) begin
          stb.incAddr = bOkay && autoInc;
          stb.setFault = !bOkay;
          stateD = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      awDoneQ <= 1'b0;
      wDoneQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      awDoneQ <= awDoneD;
      wDoneQ <= wDoneD;
    end
  end

  assign arValid = (stateQ == ST_RD_REQ);
  assign awValid = (stateQ == ST_WR_REQ) && !awDoneQ;
  assign wValid  = (stateQ == ST_WR_REQ) && !wDoneQ;
  assign busy    = (stateQ != ST_IDLE);

endmodule

// File: rtl/dbg_sysbus_dp.sv
module dbg_sysbus_dp
  import dbg_sysbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              busy,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [DATA_W-1:0] rData,
  input  logic [ID_W-1:0]   rId,
  input  logic [1:0]        rStatus,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bStatus,
  output logic              rMatch,
  output logic              rOkay,
  output logic              bMatch,
  output logic              bOkay,
  output logic [DATA_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [ID_W-1:0]   idQ,
  output logic [2:0]        errQ,
  output logic              autoIncQ,
  output logic              autoReadQ
);

  localparam int STEP = DATA_W / 8;

  logic [2:0] errD;
  logic [DATA_W-1:0] ctrlWord;

  always_comb begin
    errD = errQ;
    if (stb.wrCtrl) errD = errD & ~hostWdata[CB_ERR +: 3];
    if (stb.setFault) errD = ERR_FAULT;
    else if (stb.setStale && errD == ERR_NONE) errD = ERR_STALE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      idQ <= '0;
      errQ <= ERR_NONE;
      autoIncQ <= 1'b0;
      autoReadQ <= 1'b0;
    end else begin
      errQ <= errD;
      if (stb.wrCtrl) begin
        autoIncQ <= hostWdata[CB_AUTOINC];
        autoReadQ <= hostWdata[CB_AUTOREAD];
      end
      if (stb.wrAddr) addrQ <= hostWdata;
      else if (stb.incAddr) addrQ <= addrQ + DATA_W'(STEP);
      if (stb.loadHost) dataQ <= hostWdata;
      else if (stb.loadBus) dataQ <= rData;
      if (stb.bumpId) idQ <= idQ + 1'b1;
    end
  end

  assign rMatch = (rId == idQ);
  assign bMatch = (bId == idQ);
  assign rOkay = (rStatus == RESP_OKAY);
  assign bOkay = (bStatus == RESP_OKAY);

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CB_SIZE +: 2] = SIZE_32;
    ctrlWord[CB_AUTOINC] = autoIncQ;
    ctrlWord[CB_AUTOREAD] = autoReadQ;
    ctrlWord[CB_ERR +: 3] = errQ;
    ctrlWord[CB_BUSY] = busy;
  end

  always_comb begin
    unique case (hostSel)
      SEL_ADDR: hostRdata = addrQ;
      SEL_DATA: hostRdata = dataQ;
      SEL_CTRL: hostRdata = ctrlWord;
      default:  hostRdata = '0;
    endcase
  end

endmodule

// File: rtl/dbg_sysbus_access.sv
module dbg_sysbus_access
  import dbg_sysbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              arValid,
  input  logic              arReady,
  output logic [DATA_W-1:0] arAddr,
  output logic [ID_W-1:0]   arId,
  input  logic              rValid,
  input  logic [ID_W-1:0]   rId,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rStatus,
  output logic              awValid,
  input  logic              awReady,
  output logic [DATA_W-1:0] awAddr,
  output logic [ID_W-1:0]   awId,
  output logic              wValid,
  input  logic              wReady,
  output logic [DATA_W-1:0] wData,
  input  logic              bValid,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bStatus
);

  strobe_t stb;
  logic busy, rMatch, rOkay, bMatch, bOkay, autoIncQ, autoReadQ;
  logic [DATA_W-1:0] addrQ, dataQ;
  logic [ID_W-1:0] idQ;
  logic [2:0] errQ;

  dbg_sysbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWe(hostWe), .hostRe(hostRe), .hostSel(hostSel),
    .trigBit(hostWdata[CB_TRIG]), .clrMask(hostWdata[CB_ERR +: 3]),
    .errQ(errQ), .autoInc(autoIncQ), .autoRead(autoReadQ),
    .arReady(arReady), .rValid(rValid), .rMatch(rMatch), .rOkay(rOkay),
    .awReady(awReady), .wReady(wReady),
    .bValid(bValid), .bMatch(bMatch), .bOkay(bOkay),
    .stb(stb), .arValid(arValid), .awValid(awValid), .wValid(wValid), .busy(busy)
  );

  dbg_sysbus_dp #(.DATA_W(DATA_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .rData(rData), .rId(rId), .rStatus(rStatus), .bId(bId), .bStatus(bStatus),
    .rMatch(rMatch), .rOkay(rOkay), .bMatch(bMatch), .bOkay(bOkay),
    .addrQ(addrQ), .dataQ(dataQ), .idQ(idQ), .errQ(errQ),
    .autoIncQ(autoIncQ), .autoReadQ(autoReadQ)
  );

  assign arAddr = addrQ;
  assign awAddr = addrQ;
  assign arId = idQ;
  assign awId = idQ;
  assign wData = dataQ;

endmodule

// File: rtl/dbg_sysbus_checker.sv
module dbg_sysbus_checker #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic [1:0]        hostSel,
  input logic [DATA_W-1:0] hostWdata,
  input logic              arValid,
  input logic              arReady,
  input logic [DATA_W-1:0] arAddr,
  input logic [ID_W-1:0]   arId,
  input logic              awValid,
  input logic              awReady,
  input logic [DATA_W-1:0] awAddr,
  input logic              wValid,
  input logic              wReady,
  input logic [DATA_W-1:0] wData,
  input logic              busy,
  input logic [2:0]        errQ,
  input logic [DATA_W-1:0] addrQ
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr) && $stable(arId)); // R2

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr)); // R3

  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData)); // R3

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && (awValid || wValid))); // R3

  AST_STALE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    busy && hostWe && hostSel == 2'd1 && hostWdata != addrQ && hostWdata != addrQ + STEP
    |=> addrQ != $past(hostWdata)); // R8

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    errQ != 3'd0 && !busy && hostWe && hostSel == 2'd2 |=> !awValid && !wValid); // R10

endmodule

bind dbg_sysbus_access dbg_sysbus_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel), .hostWdata(hostWdata),
  .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arId(arId),
  .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
  .wValid(wValid), .wReady(wReady), .wData(wData),
  .busy(busy), .errQ(errQ), .addrQ(addrQ)
);

// File: tb/dbg_sysbus_access_tb.sv
module dbg_sysbus_access_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic arValid, arReady, awValid, awReady, wValid, wReady;
  logic [DW-1:0] arAddr, awAddr, wData;
  logic [IW-1:0] arId, awId;
  logic rValid, bValid;
  logic [IW-1:0] rId, bId;
  logic [DW-1:0] rData;
  logic [1:0] rStatus, bStatus;

  int nChecks = 0, nErrors = 0;
  int readCount, writeCount;
  logic [DW-1:0] lastWAddr, lastWData;
  logic badIdMode = 1'b0, badPend;
  logic [IW-1:0] keepId;
  logic [DW-1:0] keepAddr;
  logic wGate = 1'b1;
  logic awGot, wGot;
  logic [DW-1:0] awAddrCap, wDataCap;
  logic [IW-1:0] awIdCap;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbg_sysbus_access #(.DATA_W(DW), .ID_W(IW)) u_dut (.*);

  function automatic logic [DW-1:0] memFn(input logic [DW-1:0] a);
    return a * 3 + 32'h1000_0001;
  endfunction
  function automatic logic [1:0] memSt(input logic [DW-1:0] a);
    return (a[15:12] == 4'hF) ? 2'b10 : 2'b00;
  endfunction

  assign arReady = 1'b1;
  assign awReady = 1'b1;
  assign wReady = wGate;

  wire awHs = awValid && awReady;
  wire wHs = wValid && wReady;
  wire awNow = awGot || awHs;
  wire wNow = wGot || wHs;
  wire [DW-1:0] curAw = awHs ? awAddr : awAddrCap;
  wire [DW-1:0] curW = wHs ? wData : wDataCap;
  wire [IW-1:0] curAwId = awHs ? awId : awIdCap;

  // Memory model: read answered one edge after request; write answered one edge after both beats
  always @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0; bValid <= 1'b0; badPend <= 1'b0; awGot <= 1'b0; wGot <= 1'b0;
      readCount <= 0; writeCount <= 0; rId <= '0; bId <= '0; rData <= '0;
      rStatus <= 2'b00; bStatus <= 2'b00;
    end else begin
      rValid <= 1'b0;
      bValid <= 1'b0;
      if (badPend) begin
        rValid <= 1'b1; rId <= keepId; rData <= memFn(keepAddr); rStatus <= memSt(keepAddr);
        badPend <= 1'b0;
      end else if (arValid && arReady) begin
        readCount <= readCount + 1;
        if (badIdMode) begin
          rValid <= 1'b1; rId <= arId + 1'b1; rData <= 32'hDEAD_0000; rStatus <= 2'b00;
          badPend <= 1'b1; keepId <= arId; keepAddr <= arAddr;
        end else begin
          rValid <= 1'b1; rId <= arId; rData <= memFn(arAddr); rStatus <= memSt(arAddr);
        end
      end
      if (awHs) begin awAddrCap <= awAddr; awIdCap <= awId; end
      if (wHs) wDataCap <= wData;
      if (awNow && wNow) begin
        bValid <= 1'b1; bId <= curAwId; bStatus <= memSt(curAw);
        lastWAddr <= curAw; lastWData <= curW; writeCount <= writeCount + 1;
        awGot <= 1'b0; wGot <= 1'b0;
      end else begin
        awGot <= awNow; wGot <= wNow;
      end
    end
  end

  task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic hostWrite(input logic [1:0] sel, input logic [DW-1:0] v);
    hostWe = 1'b1; hostSel = sel; hostWdata = v;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [DW-1:0] v);
    hostRe = 1'b1; hostSel = sel;
    #1 v = hostRdata;
    @(negedge clk);
    hostRe = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [DW-1:0] v);
    hostSel = sel;
    #1 v = hostRdata;
  endtask

  task automatic waitIdle();
    logic [DW-1:0] c;
    for (int i = 0; i < 100; i++) begin
      peek(2'd0, c);
      if (!c[8]) return;
      @(negedge clk);
    end
    check("busy never cleared", 32'd1, 32'd0);
  endtask

  logic [DW-1:0] v;
  int rc, wc;
  logic [DW-1:0] expAddr;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 control word", v, 32'h004);
    peek(2'd1, v); check("R1 address", v, 0);
    peek(2'd2, v); check("R1 data", v, 0);
    check("R1 valids", {29'd0, arValid, awValid, wValid}, 0);

    // R2 single read, request timing and result
    hostWrite(2'd1, 32'h100);
    hostWrite(2'd0, 32'h001);
    check("R2 arValid next cycle", {31'd0, arValid}, 1);
    check("R2 arAddr", arAddr, 32'h100);
    peek(2'd0, v); check("R2 busy set", {31'd0, v[8]}, 1);
    waitIdle();
    peek(2'd2, v); check("R2 read data", v, memFn(32'h100));
    peek(2'd1, v); check("R4 no increment when off", v, 32'h100);

    // R4 sweep of reads with and without increment
    for (int inc = 0; inc < 2; inc++) begin
      for (int base = 0; base < 4; base++) begin
        expAddr = 32'h1000 + base * 32'h40;
        hostWrite(2'd1, expAddr);
        for (int k = 0; k < 3; k++) begin
          hostWrite(2'd0, 32'h001 | (inc << 3));
          waitIdle();
          peek(2'd2, v); check("R4 read data in sweep", v, memFn(expAddr));
          if (inc != 0) expAddr = expAddr + 4;
        end
        peek(2'd1, v); check("R4 address after reads", v, expAddr);
      end
    end

    // R3 write with stalled data beat
    hostWrite(2'd0, 32'h000);
    hostWrite(2'd1, 32'h200);
    wGate = 1'b0;
    wc = writeCount;
    hostWrite(2'd2, 32'hCAFE_0001);
    check("R3 both valids together", {30'd0, awValid, wValid}, 3);
    check("R3 awAddr", awAddr, 32'h200);
    check("R3 wData", wData, 32'hCAFE_0001);
    @(negedge clk);
    check("R3 only data beat held", {30'd0, awValid, wValid}, 1);
    check("R3 wData stable", wData, 32'hCAFE_0001);
    peek(2'd0, v); check("R3 busy while open", {31'd0, v[8]}, 1);
    wGate = 1'b1;
    waitIdle();
    check("R3 memory write addr", lastWAddr, 32'h200);
    check("R3 memory write data", lastWData, 32'hCAFE_0001);
    check("R3 one write", writeCount, wc + 1);

    // R4 write sweep with increment
    hostWrite(2'd0, 32'h008);
    hostWrite(2'd1, 32'h2000);
    for (int k = 0; k < 4; k++) begin
      hostWrite(2'd2, 32'hDAFA_0000 + k);
      waitIdle();
      check("R4 write addr step", lastWAddr, 32'h2000 + 4 * k);
      check("R4 write data", lastWData, 32'hDAFA_0000 + k);
    end
    peek(2'd1, v); check("R4 address after writes", v, 32'h2010);

    // R5 read-ahead
    hostWrite(2'd0, 32'h018);
    hostWrite(2'd1, 32'h300);
    hostWrite(2'd0, 32'h019);
    waitIdle();
    for (int k = 0; k < 3; k++) begin
      hostRead(2'd2, v);
      check("R5 read-ahead returns current data", v, memFn(32'h300 + 4 * k));
      check("R5 read launched", {31'd0, arValid}, 1);
      check("R5 launched address", arAddr, 32'h304 + 4 * k);
      waitIdle();
    end
    hostWrite(2'd0, 32'h000);
    rc = readCount;
    hostRead(2'd2, v);
    check("R5 last fetched data", v, memFn(32'h30C));
    @(negedge clk);
    check("R5 no launch when off", readCount, rc);

    // R6 response with wrong tag ignored
    badIdMode = 1'b1;
    hostWrite(2'd1, 32'h400);
    hostWrite(2'd0, 32'h001);
    waitIdle();
    badIdMode = 1'b0;
    peek(2'd2, v); check("R6 wrong-tag data ignored", v, memFn(32'h400));

    // R7 faulting read
    hostWrite(2'd1, 32'hF000);
    hostWrite(2'd0, 32'h009);
    waitIdle();
    peek(2'd0, v); check("R7 error field", {29'd0, v[7:5]}, 2);
    peek(2'd2, v); check("R7 data kept", v, memFn(32'h400));
    peek(2'd1, v); check("R7 address kept", v, 32'hF000);

    // R10 error blocks launches
    wc = writeCount; rc = readCount;
    hostWrite(2'd2, 32'h1234);
    check("R10 no write request", {31'd0, awValid}, 0);
    hostWrite(2'd0, 32'h011);
    check("R10 no read request", {31'd0, arValid}, 0);
    hostRead(2'd2, v);
    @(negedge clk);
    check("R10 read counts", readCount, rc);
    check("R10 write counts", writeCount, wc);
    peek(2'd2, v); check("R10 data kept", v, memFn(32'h400));

    // R9 write-one-to-clear per bit
    hostWrite(2'd0, 32'h020);
    peek(2'd0, v); check("R9 zero bits kept", {29'd0, v[7:5]}, 2);
    hostWrite(2'd0, 32'h040);
    peek(2'd0, v); check("R9 cleared", {29'd0, v[7:5]}, 0);

    // R8 host access while busy
    hostWrite(2'd1, 32'h500);
    wGate = 1'b0;
    hostWrite(2'd2, 32'h55);
    hostWrite(2'd1, 32'h999);
    peek(2'd0, v); check("R8 stale code", {29'd0, v[7:5]}, 7);
    peek(2'd1, v); check("R8 address kept", v, 32'h500);
    hostWrite(2'd2, 32'h66);
    peek(2'd2, v); check("R8 data kept", v, 32'h55);
    wGate = 1'b1;
    waitIdle();
    check("R8 bus saw first value", lastWData, 32'h55);
    check("R8 bus saw first address", lastWAddr, 32'h500);
    peek(2'd0, v); check("R8 code persists", {29'd0, v[7:5]}, 7);
    hostWrite(2'd0, 32'h0E0);
    peek(2'd0, v); check("R9 full clear", {29'd0, v[7:5]}, 0);

    // R7 faulting write
    hostWrite(2'd1, 32'hF004);
    hostWrite(2'd2, 32'h77);
    waitIdle();
    peek(2'd0, v); check("R7 write fault code", {29'd0, v[7:5]}, 2);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule